// File: doc/BRIEF.md
# Prescaled Period-Match Timer

This block is a 16-bit up-counter that advances on a divided tick and restarts from zero when it reaches a programmable period. The tick comes from one of two places. The first is the system clock itself, which can be qualified by a gate input so that the timer measures how long the gate stays high. The second is an external tick line, which is resampled in the system clock domain and counted on each rising edge. A two-bit field picks one of four divide ratios for the selected tick. The counter wraps when it matches the period, and each wrap raises a one-cycle match pulse.

Software reaches the block through three write strobes: control, period and count. It reads back the control word, the period and the live count. Bits that have no meaning under the selected tick source read back as zero. Bits that are not implemented also read as zero. Control is meant to be changed while the timer is stopped. Any control write restarts the divider, so the first divided tick always comes a full ratio after the write.

Top module: `prescaled_match_timer`

## Requirements
- R1: After reset the count is 0x0000, the period is 0xFFFF, the control readback is 0x0000 and the match output is low.
- R2: While enabled, the count goes up by one on every divided tick. A count write loads the written value on the next clock edge and takes priority over a tick.
- R3: On a divided tick at which the count equals the period, the count becomes 0x0000 instead of incrementing. Match is high for exactly the clock cycle in which that zero is first visible.
- R4: Control bits 5:4 select the divide ratio: 00 gives 1, 01 gives 8, 10 gives 64 and 11 gives 256. With ratio N and an ungated internal tick, the count first advances N clocks after the enabling control write and then every N clocks.
- R5: While control bit 15 (enable) is 0, the count holds its value and the divider is held at zero.
- R6: With a period of 0, the count stays at 0x0000 and match pulses on every divided tick.
- R7: Control readback bits 14:8, 6, 3 and 0 always read 0.
- R8: Control bit 7 (gate) has an effect only when bit 1 is 0. In that case each clock counts as a tick only while gate_in is high. When bit 1 is 1, bit 7 reads back 0 and gate_in is ignored.
- R9: Control bit 2 (sync) reads back 0 when bit 1 is 0, and it then has no effect on counting.
- R10: Every control write clears the divider, even a write that does not change the value.
- R11: With control bit 1 = 1, each rising edge of ext_tick_in is one tick ahead of the divider, and a steady level produces no ticks.
- R12: With bit 1 = 1 at ratio 1, a rising edge of ext_tick_in driven between clock edges shows up in the count 3 clock edges later when bit 2 is 1, and 2 clock edges later when bit 2 is 0.
- R13: A count above the period runs up through 0xFFFF to 0x0000 with no match pulse, and then continues counting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctrl_we | input | 1 | Control write strobe |
| ctrl_wdata | input | 16 | Control write value |
| ctrl_rdata | output | 16 | Control readback with masked fields |
| period_we | input | 1 | Period write strobe |
| period_wdata | input | 16 | Period write value |
| period_q | output | 16 | Current period |
| count_we | input | 1 | Count write strobe |
| count_wdata | input | 16 | Count write value |
| count_q | output | 16 | Current count |
| gate_in | input | 1 | Gate qualifier for internal ticks, synchronous to clk |
| ext_tick_in | input | 1 | External tick line, asynchronous |
| match_pulse | output | 1 | One-cycle pulse on each period wrap |

## Verification
The hardest condition to reach from the ports is a divider that is part-way through a ratio at the moment control is rewritten. A clear that goes missing there changes only when the next tick lands, not the values the count passes through. To reach it, the stimulus runs at ratio 8 for five clocks and then writes the same control value again. It then checks that the count does not move until eight full clocks after that write.

The external path is checked for exact latency as well as edge count. The stimulus drives a single rising edge between clock edges. It samples the count on the cycle just before and the cycle just after the expected arrival, once with the sync bit set and once with it clear.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int CTRL_W = 16;
  localparam int PRE_W  = 8;
  localparam int EN_B   = 15;
  localparam int GATE_B = 7;
  localparam int PS_LO  = 4;
  localparam int SYNC_B = 2;
  localparam int SRC_B  = 1;

  localparam logic [CTRL_W-1:0] IMPL_MASK =
    (CTRL_W'(1) << EN_B) | (CTRL_W'(1) << GATE_B) | (CTRL_W'(3) << PS_LO) |
    (CTRL_W'(1) << SYNC_B) | (CTRL_W'(1) << SRC_B);

  typedef struct packed {
    logic       en;
    logic       gate_en;
    logic [1:0] ps;
    logic       sync;
    logic       src;
  } ctrl_t;

  function automatic ctrl_t unpack_ctrl(input logic [CTRL_W-1:0] w);
    ctrl_t c;
    c.en      = w[EN_B];
    c.gate_en = w[GATE_B];
    c.ps      = w[PS_LO +: 2];
    c.sync    = w[SYNC_B];
    c.src     = w[SRC_B];
    return c;
  endfunction

  // Readback: gate hidden under external source, sync hidden under internal.
  function automatic logic [CTRL_W-1:0] ctrl_view(input ctrl_t c);
    logic [CTRL_W-1:0] v;
    v             = '0;
    v[EN_B]       = c.en;
    v[GATE_B]     = c.gate_en & ~c.src;
    v[PS_LO +: 2] = c.ps;
    v[SYNC_B]     = c.sync & c.src;
    v[SRC_B]      = c.src;
    return v;
  endfunction

  // Divide ratio is 2**shift: 1, 8, 64, 256.
  function automatic int unsigned ps_shift(input logic [1:0] ps);
    case (ps)
      2'b00:   return 0;
      2'b01:   return 3;
      2'b10:   return 6;
      default: return 8;
    endcase
  endfunction

  function automatic logic [PRE_W-1:0] ps_limit(input logic [1:0] ps);
    logic [PRE_W:0] full;
    full = ((PRE_W+1)'(1) << ps_shift(ps)) - (PRE_W+1)'(1);
    return full[PRE_W-1:0];
  endfunction
endpackage

// File: rtl/tmr_tick_src.sv
module tmr_tick_src (
  input  logic clk,
  input  logic rst_n,
  input  logic src_ext,
  input  logic sync_sel,
  input  logic gate_en,
  input  logic gate_in,
  input  logic ext_in,
  output logic ext_edge,
  output logic base_tick
);
  logic [2:0] smp;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) smp <= '0;
    else        smp <= {smp[1:0], ext_in};
  end

  // Sync set: edge seen after two flops; clear: after one.
  assign ext_edge  = sync_sel ? (smp[1] & ~smp[2]) : (smp[0] & ~smp[1]);
  assign base_tick = src_ext ? ext_edge : (~gate_en | gate_in);

  // R11: a steady sampled level gives no edge
  assert_no_edge_on_level_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (smp[2] == smp[1] && smp[1] == smp[0]) |-> !ext_edge);
endmodule

// File: rtl/tmr_prescaler.sv
module tmr_prescaler
  import tmr_pkg::*;
#(
  parameter int W = PRE_W
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr,
  input  logic       en,
  input  logic [1:0] ps,
  input  logic       base_tick,
  output logic       presc_tick
);
  logic [W-1:0] pre_cnt;
  logic [W-1:0] limit;

  assign limit      = W'(ps_limit(ps));
  assign presc_tick = en & base_tick & (pre_cnt == limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                pre_cnt <= '0;
    else if (clr)              pre_cnt <= '0;
    else if (en && base_tick)  pre_cnt <= presc_tick ? '0 : pre_cnt + W'(1);
  end

  // R4: above ratio 1 two divided ticks never come back to back
  assert_tick_gap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (presc_tick && ps != 2'b00) |=> !presc_tick);
  // R5: a stopped timer produces no divided tick
  assert_no_tick_when_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> !presc_tick);
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic [W-1:0] period,
  output logic [W-1:0] cnt,
  output logic         match,
  output logic         wrap
);
  localparam logic [W-1:0] ALL_ONES = '1;

  assign wrap = tick & ~load & (cnt == period);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      match <= 1'b0;
    end else begin
      match <= wrap;
      if (load)       cnt <= load_val;
      else if (wrap)  cnt <= '0;
      else if (tick)  cnt <= cnt + W'(1);
    end
  end

  // R2: a tick off the period steps by one
  assert_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !load && cnt != period) |=> cnt == $past(cnt) + W'(1));
  // R3: match always coincides with a zero count
  assert_match_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    match |-> cnt == '0);
  // R13: natural rollover carries no match
  assert_rollover_quiet_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !load && cnt == ALL_ONES && period != ALL_ONES) |=> (cnt == '0 && !match));
endmodule

// File: rtl/prescaled_match_timer.sv
module prescaled_match_timer
  import tmr_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctrl_we,
  input  logic [CTRL_W-1:0] ctrl_wdata,
  output logic [CTRL_W-1:0] ctrl_rdata,
  input  logic              period_we,
  input  logic [CNT_W-1:0]  period_wdata,
  output logic [CNT_W-1:0]  period_q,
  input  logic              count_we,
  input  logic [CNT_W-1:0]  count_wdata,
  output logic [CNT_W-1:0]  count_q,
  input  logic              gate_in,
  input  logic              ext_tick_in,
  output logic              match_pulse
);
  ctrl_t ctrl_q;
  logic  base_tick;
  logic  ext_edge;
  logic  presc_tick;
  logic  presc_clr;
  logic  wrap_evt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q   <= '0;
      period_q <= '1;
    end else begin
      if (ctrl_we)   ctrl_q   <= unpack_ctrl(ctrl_wdata);
      if (period_we) period_q <= period_wdata;
    end
  end

  assign ctrl_rdata = ctrl_view(ctrl_q);
  assign presc_clr  = ctrl_we | ~ctrl_q.en;

  tmr_tick_src u_src (
    .clk       (clk),
    .rst_n     (rst_n),
    .src_ext   (ctrl_q.src),
    .sync_sel  (ctrl_q.sync),
    .gate_en   (ctrl_q.gate_en),
    .gate_in   (gate_in),
    .ext_in    (ext_tick_in),
    .ext_edge  (ext_edge),
    .base_tick (base_tick)
  );

  tmr_prescaler #(.W(PRE_W)) u_pre (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr        (presc_clr),
    .en         (ctrl_q.en),
    .ps         (ctrl_q.ps),
    .base_tick  (base_tick),
    .presc_tick (presc_tick)
  );

  tmr_counter #(.W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (presc_tick),
    .load     (count_we),
    .load_val (count_wdata),
    .period   (period_q),
    .cnt      (count_q),
    .match    (match_pulse),
    .wrap     (wrap_evt)
  );

  // R5: stopped timer holds its count
  assert_hold_when_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl_q.en && !count_we) |=> $stable(count_q));
  // R7: unimplemented bits read zero
  assert_unimpl_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_rdata & ~IMPL_MASK) == '0);
  // R8: gate bit hidden under external source
  assert_gate_hidden_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_rdata[SRC_B] |-> !ctrl_rdata[GATE_B]);
  // R9: sync bit hidden under internal source
  assert_sync_hidden_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_rdata[SRC_B] |-> !ctrl_rdata[SYNC_B]);
  // R3: a wrap is followed by a match pulse
  assert_wrap_match_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_evt |=> match_pulse);
endmodule

// File: tb/prescaled_match_timer_tb.sv
`timescale 1ns/1ps
module prescaled_match_timer_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ctrl_we = 1'b0, period_we = 1'b0, count_we = 1'b0;
  logic [15:0] ctrl_wdata = '0, period_wdata = '0, count_wdata = '0;
  logic [15:0] ctrl_rdata, period_q, count_q;
  logic        gate_in = 1'b0, ext_tick_in = 1'b0, match_pulse;

  prescaled_match_timer u_dut (
    .clk(clk), .rst_n(rst_n),
    .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata), .ctrl_rdata(ctrl_rdata),
    .period_we(period_we), .period_wdata(period_wdata), .period_q(period_q),
    .count_we(count_we), .count_wdata(count_wdata), .count_q(count_q),
    .gate_in(gate_in), .ext_tick_in(ext_tick_in), .match_pulse(match_pulse)
  );

  always #4 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  typedef struct {
    int          at;
    logic [15:0] cnt;
    logic        m;
    string       tag;
  } exp_t;
  exp_t q[$];

  // Monitor: pops expectations whose cycle has come.
  always @(negedge clk) begin
    exp_t e;
    while (q.size() > 0 && q[0].at <= cyc) begin
      e = q.pop_front();
      n_chk++;
      if (e.at != cyc || count_q !== e.cnt || match_pulse !== e.m) begin
        n_bad++;
        $display("FAIL %s cyc %0d: count=%h match=%b expected count=%h match=%b",
                 e.tag, cyc, count_q, match_pulse, e.cnt, e.m);
      end
    end
  end

  task automatic push(int at, logic [15:0] c, logic m, string tag);
    exp_t e;
    e.at = at; e.cnt = c; e.m = m; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic drain();
    while (q.size() != 0) @(negedge clk);
  endtask

  task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr_ctrl(logic [15:0] v);
    @(negedge clk); ctrl_we = 1'b1; ctrl_wdata = v;
    @(negedge clk); ctrl_we = 1'b0;
  endtask
  task automatic wr_per(logic [15:0] v);
    @(negedge clk); period_we = 1'b1; period_wdata = v;
    @(negedge clk); period_we = 1'b0;
  endtask
  task automatic wr_cnt(logic [15:0] v);
    @(negedge clk); count_we = 1'b1; count_wdata = v;
    @(negedge clk); count_we = 1'b0;
  endtask
  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      summary();
    end
  end

  initial begin
    int b;
    idle(3);
    rst_n = 1'b1;
    idle(1);
    // R1 reset state
    chk("R1 count", count_q, 16'h0000);
    chk("R1 period", period_q, 16'hFFFF);
    chk("R1 ctrl", ctrl_rdata, 16'h0000);
    chk("R1 match", {15'd0, match_pulse}, 16'h0000);

    // R2/R3: ratio 1, period 4
    wr_per(16'd4); wr_cnt(16'd0); wr_ctrl(16'h8000); b = cyc;
    for (int k = 1; k <= 12; k++)
      push(b + k, 16'(k % 5), (k % 5) == 0, (k % 5) == 0 ? "R3" : "R2");
    drain();

    // R4: ratio 8
    wr_ctrl(16'h0000); wr_per(16'hFFFF); wr_cnt(16'd0); wr_ctrl(16'h8010); b = cyc;
    for (int k = 1; k <= 24; k++) push(b + k, 16'(k / 8), 1'b0, "R4 div8");
    drain();
    // R4: ratio 64
    wr_ctrl(16'h0000); wr_cnt(16'd0); wr_ctrl(16'h8020); b = cyc;
    push(b + 63, 16'd0, 1'b0, "R4 div64"); push(b + 64, 16'd1, 1'b0, "R4 div64");
    push(b + 127, 16'd1, 1'b0, "R4 div64"); push(b + 128, 16'd2, 1'b0, "R4 div64");
    drain();
    // R4: ratio 256
    wr_ctrl(16'h0000); wr_cnt(16'd0); wr_ctrl(16'h8030); b = cyc;
    push(b + 255, 16'd0, 1'b0, "R4 div256"); push(b + 256, 16'd1, 1'b0, "R4 div256");
    push(b + 512, 16'd2, 1'b0, "R4 div256");
    drain();

    // R5: disabled holds
    wr_ctrl(16'h0000); wr_cnt(16'd5); b = cyc;
    for (int k = 1; k <= 10; k++) push(b + k, 16'd5, 1'b0, "R5");
    drain();

    // R6: period zero at ratio 8, then ratio 1
    wr_per(16'd0); wr_cnt(16'd0); wr_ctrl(16'h8010); b = cyc;
    for (int k = 1; k <= 24; k++) push(b + k, 16'd0, (k % 8) == 0, "R6 div8");
    drain();
    wr_ctrl(16'h0000); wr_ctrl(16'h8000); b = cyc;
    for (int k = 1; k <= 4; k++) push(b + k, 16'd0, 1'b1, "R6 div1");
    drain();

    // R13: rollover above period
    wr_ctrl(16'h0000); wr_per(16'd5); wr_cnt(16'hFFFE); wr_ctrl(16'h8000); b = cyc;
    push(b + 1, 16'hFFFF, 1'b0, "R13"); push(b + 2, 16'h0000, 1'b0, "R13");
    push(b + 3, 16'h0001, 1'b0, "R13");
    drain();

    // R10: rewriting control clears a half-run divider
    wr_ctrl(16'h0000); wr_per(16'hFFFF); wr_cnt(16'd0); wr_ctrl(16'h8010);
    idle(5);
    wr_ctrl(16'h8010); b = cyc;
    push(b + 2, 16'd0, 1'b0, "R10"); push(b + 7, 16'd0, 1'b0, "R10");
    push(b + 8, 16'd1, 1'b0, "R10");
    drain();

    // R7/R8/R9 readback
    wr_ctrl(16'h7FFF);
    chk("R7 R8 readback ext", ctrl_rdata, 16'h0036);
    wr_ctrl(16'h7FFD);
    chk("R7 R9 readback int", ctrl_rdata, 16'h00B0);
    wr_ctrl(16'hFFFF);
    chk("R7 readback all", ctrl_rdata, 16'h8036);
    // R9: sync set under internal source still counts every clock
    wr_ctrl(16'h0000); wr_cnt(16'd0); wr_ctrl(16'h8004); b = cyc;
    push(b + 3, 16'd3, 1'b0, "R9");
    drain();

    // R8: gated accumulation
    wr_ctrl(16'h0000); wr_cnt(16'd0); gate_in = 1'b0; wr_ctrl(16'h8080);
    idle(3);
    chk("R8 gate low", count_q, 16'd0);
    gate_in = 1'b1; idle(3); gate_in = 1'b0; idle(4);
    chk("R8 gate 3", count_q, 16'd3);
    gate_in = 1'b1; idle(2); gate_in = 1'b0; idle(2);
    chk("R8 gate 5", count_q, 16'd5);

    // R11/R12: external ticks, sync set, gate set but ignored
    wr_ctrl(16'h0000); wr_cnt(16'd0); ext_tick_in = 1'b0; wr_ctrl(16'h8086);
    idle(4);
    chk("R11 level", count_q, 16'd0);
    ext_tick_in = 1'b1; idle(2);
    chk("R12 sync early", count_q, 16'd0);
    idle(1);
    chk("R12 sync on time", count_q, 16'd1);
    ext_tick_in = 1'b0; idle(3);
    for (int p = 0; p < 4; p++) begin
      ext_tick_in = 1'b1; idle(2); ext_tick_in = 1'b0; idle(2);
    end
    idle(4);
    chk("R11 R8 edges", count_q, 16'd5);
    // R12: sync clear
    wr_ctrl(16'h0000); wr_cnt(16'd0); wr_ctrl(16'h8082);
    idle(3);
    ext_tick_in = 1'b1; idle(1);
    chk("R12 nosync early", count_q, 16'd0);
    idle(1);
    chk("R12 nosync on time", count_q, 16'd1);
    idle(4);
    chk("R11 held high", count_q, 16'd1);

    done = 1'b1;
    summary();
  end
endmodule